// File: doc/BRIEF.md
# Hierarchical Interrupt Collapsing Controller

This block gathers the interrupt sources of a line-termination chip into a small set of byte-wide status registers. A host microcontroller reads and writes them over a simple parallel bus. Three lower-level interrupt groups are each folded into one summary bit: the U line interface, the S line interface and the general-purpose I/O group. Two external interrupt pins are first passed through synchronisers and then copied into status bits. A built-in frame timer raises a flag once every 125 µs, so that the host can pace its access to bearer-channel data.

Every status bit except the frame flag is a plain level. It is high while its source is active and drops by itself when the source goes away. The frame flag is set when the frame counter wraps and is cleared when the host reads the first status register. Each status bit has an enable bit. The block drives one active-high interrupt request, which is the OR of all enabled status bits.

Top module: `irq_collapse`

## Requirements
- R1: While reset is high, and on the first clock after it, `bus_rdata`, `cpu_irq`, all status bits and all enable bits are 0.
- R2: A read strobe at address A returns the register data on `bus_rdata` at the next clock edge. Status register 0 is at 0, status register 1 at 1, enable register 0 at 2 and enable register 1 at 3. Addresses 4 to 7 read 0. Unused bits read 0: bits 7:5 at addresses 0 and 2, and bits 7:1 at addresses 1 and 3.
- R3: Status register 0 holds the GPIO summary in bit 0, the S summary in bit 1 and the U summary in bit 2. Each summary is the OR of its own sub-flag vector, registered once. It returns to 0 by itself one clock after its sub-flags all go to 0.
- R4: Status register 0 bit 4 follows pin `ext_pin0`, and status register 1 bit 0 follows pin `ext_pin1`. Each lags its pin by three clocks: a two-stage synchroniser and then the status register.
- R5: Status register 0 bit 3 is set on every FRAME_EN-th clock on which `clk_en` is high, counted from reset.
- R6: A read of address 0 clears status register 0 bit 3, and the read returns the value from before the clear. If the counter wraps on the same clock, the bit is set instead. Reads of other addresses leave the bit unchanged.
- R7: Enable register 0 (address 2, bits 4:0, same bit positions as status register 0) and enable register 1 (address 3, bit 0) take `bus_wdata` on a write strobe. Writes to other addresses change no register.
- R8: `cpu_irq` is high exactly when some status bit and its enable bit were both 1 on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Frame-count enable pulse |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| usub_flags | input | U_W (8) | U interface sub-interrupt flags |
| ssub_flags | input | S_W (8) | S interface sub-interrupt flags |
| gpio_flags | input | G_W (8) | GPIO sub-interrupt flags |
| ext_pin0 | input | 1 | External interrupt pin 0, asynchronous |
| ext_pin1 | input | 1 | External interrupt pin 1, asynchronous |
| cpu_irq | output | 1 | Active-high interrupt request to the host |

## Verification
A wrong summary or pin bit shows up in two places. The first host read of address 0 or 1 after the fault returns the wrong value, and `cpu_irq` goes wrong one clock after the bad status bit once that bit is enabled. A frame counter with the wrong phase moves bit 3 by whole `clk_en` pulses. A directed run of exactly FRAME_EN-1 and then FRAME_EN pulses from reset exposes this on the next read. A frame flag that does not clear, or that loses the collision with a wrap, is caught by the following read of address 0. A reference model steps through every clock and compares `cpu_irq` on each clock and `bus_rdata` after every read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int A_ST0 = 0;
  localparam int A_ST1 = 1;
  localparam int A_EN0 = 2;
  localparam int A_EN1 = 3;

  localparam int B_GPIO = 0;
  localparam int B_SSUM = 1;
  localparam int B_USUM = 2;
  localparam int B_TICK = 3;
  localparam int B_XP0  = 4;
  localparam int ST0_W  = 5;
  localparam int ST1_W  = 1;
  localparam int DATA_W = 8;
endpackage

// File: rtl/irq_or_reduce.sv
module irq_or_reduce #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  output logic         summary
);
  always_ff @(posedge clk) begin
    if (rst) summary <= 1'b0;
    else     summary <= |flags;
  end
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_frame_timer.sv
module irq_frame_timer #(
  parameter int FRAME_EN = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic clr,
  output logic wrap,
  output logic flag
);
  localparam int CNT_W = (FRAME_EN > 1) ? $clog2(FRAME_EN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_EN - 1);

  logic [CNT_W-1:0] cnt;

  assign wrap = clk_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clk_en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/irq_collapse.sv
module irq_collapse
  import irq_pkg::*;
#(
  parameter int U_W         = 8,
  parameter int S_W         = 8,
  parameter int G_W         = 8,
  parameter int ADDR_W      = 3,
  parameter int FRAME_EN    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [U_W-1:0]    usub_flags,
  input  logic [S_W-1:0]    ssub_flags,
  input  logic [G_W-1:0]    gpio_flags,
  input  logic              ext_pin0,
  input  logic              ext_pin1,
  output logic              cpu_irq
);
  logic             g_sum, s_sum, u_sum;
  logic [1:0]       pin_s;
  logic [1:0]       xpin_q;
  logic             tick_flag, frame_wrap;
  logic [ST0_W-1:0] st0, en0;
  logic [ST1_W-1:0] st1, en1;
  logic             rd_st0;
  logic [7:0]       rd_mux;

  irq_or_reduce #(.W(G_W)) u_gpio_sum (.clk(clk), .rst(rst), .flags(gpio_flags), .summary(g_sum));
  irq_or_reduce #(.W(S_W)) u_s_sum    (.clk(clk), .rst(rst), .flags(ssub_flags), .summary(s_sum));
  irq_or_reduce #(.W(U_W)) u_u_sum    (.clk(clk), .rst(rst), .flags(usub_flags), .summary(u_sum));

  irq_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d({ext_pin1, ext_pin0}), .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) xpin_q <= '0;
    else     xpin_q <= pin_s;
  end

  assign rd_st0 = bus_rd && (bus_addr == ADDR_W'(A_ST0));

  irq_frame_timer #(.FRAME_EN(FRAME_EN)) u_frame (
    .clk(clk), .rst(rst), .clk_en(clk_en), .clr(rd_st0),
    .wrap(frame_wrap), .flag(tick_flag)
  );

  always_comb begin
    st0         = '0;
    st0[B_GPIO] = g_sum;
    st0[B_SSUM] = s_sum;
    st0[B_USUM] = u_sum;
    st0[B_TICK] = tick_flag;
    st0[B_XP0]  = xpin_q[0];
    st1         = xpin_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en0 <= '0;
      en1 <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_EN0)) en0 <= bus_wdata[ST0_W-1:0];
      if (bus_addr == ADDR_W'(A_EN1)) en1 <= bus_wdata[ST1_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_ST0): rd_mux[ST0_W-1:0] = st0;
      ADDR_W'(A_ST1): rd_mux[ST1_W-1:0] = st1;
      ADDR_W'(A_EN0): rd_mux[ST0_W-1:0] = en0;
      ADDR_W'(A_EN1): rd_mux[ST1_W-1:0] = en1;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= (|(st0 & en0)) || (|(st1 & en1));
  end
endmodule

// File: rtl/irq_collapse_chk.sv
module irq_collapse_chk #(
  parameter int U_W    = 8,
  parameter int S_W    = 8,
  parameter int G_W    = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              cpu_irq,
  input logic [U_W-1:0]    usub_flags,
  input logic [S_W-1:0]    ssub_flags,
  input logic [G_W-1:0]    gpio_flags,
  input logic              ext_pin0,
  input logic              ext_pin1,
  input logic [4:0]        st0,
  input logic [0:0]        st1,
  input logic [4:0]        en0,
  input logic [0:0]        en1,
  input logic              frame_wrap,
  input logic              tick_flag
);
  logic [1:0] live = 2'd0;

  always_ff @(posedge clk) begin
    if (rst)              live <= 2'd0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (bus_rdata == 8'h00 && !cpu_irq && st0 == 5'd0 && en0 == 5'd0)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr == '0) |=> (bus_rdata[7:5] == 3'b000)); // R2
  AST_U_SUMMARY: assert property (@(posedge clk) disable iff (rst || live == 2'd0) st0[2] == $past(|usub_flags)); // R3
  AST_S_SUMMARY: assert property (@(posedge clk) disable iff (rst || live == 2'd0) st0[1] == $past(|ssub_flags)); // R3
  AST_G_SUMMARY: assert property (@(posedge clk) disable iff (rst || live == 2'd0) st0[0] == $past(|gpio_flags)); // R3
  AST_PIN0_LAG: assert property (@(posedge clk) disable iff (rst || live != 2'd3) st0[4] == $past(ext_pin0, 3)); // R4
  AST_PIN1_LAG: assert property (@(posedge clk) disable iff (rst || live != 2'd3) st1[0] == $past(ext_pin1, 3)); // R4
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst) frame_wrap |=> tick_flag); // R5
  AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr == '0 && !frame_wrap) |=> !tick_flag); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst) !(bus_wr && bus_addr == ADDR_W'(2)) |=> $stable(en0)); // R7
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst || live == 2'd0) cpu_irq == $past((|(st0 & en0)) || (|(st1 & en1)))); // R8
endmodule

bind irq_collapse irq_collapse_chk #(.U_W(U_W), .S_W(S_W), .G_W(G_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .usub_flags(usub_flags),
  .ssub_flags(ssub_flags), .gpio_flags(gpio_flags), .ext_pin0(ext_pin0),
  .ext_pin1(ext_pin1), .st0(st0), .st1(st1), .en0(en0), .en1(en1),
  .frame_wrap(frame_wrap), .tick_flag(tick_flag)
);

// File: tb/irq_collapse_tb.sv
module irq_collapse_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_EN   = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] usub_flags = '0, ssub_flags = '0, gpio_flags = '0;
  logic       ext_pin0 = 1'b0, ext_pin1 = 1'b0;
  logic       cpu_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collapse #(.FRAME_EN(FRAME_EN)) u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .usub_flags(usub_flags), .ssub_flags(ssub_flags), .gpio_flags(gpio_flags),
    .ext_pin0(ext_pin0), .ext_pin1(ext_pin1), .cpu_irq(cpu_irq)
  );

  // Reference model, advanced on each rising edge from the requirements
  logic       g_m, s_m, u_m, tick_m, x0_m, x1_m, irq_m, rdv_m;
  logic [1:0] s1_m, s2_m;
  logic [4:0] en0_m;
  logic       en1_m;
  logic [7:0] rdata_m;
  logic [2:0] ra_m;
  int         cnt_m;

  function automatic logic [7:0] st0_f();
    return {3'b000, x0_m, tick_m, u_m, s_m, g_m};
  endfunction

  function automatic logic [7:0] reg_f(input logic [2:0] a);
    case (a)
      3'd0:    return st0_f();
      3'd1:    return {7'd0, x1_m};
      3'd2:    return {3'd0, en0_m};
      3'd3:    return {7'd0, en1_m};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {g_m, s_m, u_m, tick_m, x0_m, x1_m, irq_m, rdv_m, en1_m} = '0;
      s1_m = '0; s2_m = '0; en0_m = '0; rdata_m = '0; ra_m = '0; cnt_m = 0;
    end else begin
      logic wrap;
      irq_m = (|(st0_f() & {3'd0, en0_m})) || (x1_m && en1_m);
      rdv_m = bus_rd;
      ra_m  = bus_addr;
      if (bus_rd) rdata_m = reg_f(bus_addr);
      wrap = clk_en && (cnt_m == FRAME_EN - 1);
      if (clk_en) cnt_m = wrap ? 0 : cnt_m + 1;
      if (wrap) tick_m = 1'b1;
      else if (bus_rd && bus_addr == 3'd0) tick_m = 1'b0;
      g_m = |gpio_flags; s_m = |ssub_flags; u_m = |usub_flags;
      x0_m = s2_m[0]; x1_m = s2_m[1];
      s2_m = s1_m; s1_m = {ext_pin1, ext_pin0};
      if (bus_wr && bus_addr == 3'd2) en0_m = bus_wdata[4:0];
      if (bus_wr && bus_addr == 3'd3) en1_m = bus_wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 cpu_irq vs model", {7'd0, cpu_irq}, {7'd0, irq_m});
      if (rdv_m) begin
        case (ra_m)
          3'd0:       chk("R3 read status0", bus_rdata, rdata_m);
          3'd1:       chk("R4 read status1", bus_rdata, rdata_m);
          3'd2, 3'd3: chk("R7 read enable", bus_rdata, rdata_m);
          default:    chk("R2 read unmapped", bus_rdata, rdata_m);
        endcase
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk);
      clk_en = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0;
    end
    @(negedge clk);
    clk_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    chk("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);
    do_read(3'd2, d); chk("R1 enable0 after reset", d, 8'h00);

    // Frame flag from reset phase: FRAME_EN-1 pulses then the FRAME_EN-th
    pulses(FRAME_EN - 1);
    do_read(3'd0, d); chk("R5 no flag before wrap", d, 8'h00);
    pulses(1);
    do_read(3'd0, d); chk("R5 flag after wrap", d, 8'h08);
    do_read(3'd0, d); chk("R6 flag cleared by read", d, 8'h00);
    // Read of another address leaves the flag
    pulses(FRAME_EN);
    do_read(3'd1, d);
    do_read(3'd0, d); chk("R6 other read keeps flag", d, 8'h08);
    // Wrap and clearing read in the same clock: set wins
    pulses(FRAME_EN - 1);
    @(negedge clk);
    clk_en = 1'b1; bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk);
    clk_en = 1'b0; bus_rd = 1'b0;
    chk("R6 collided read returns old value", bus_rdata, 8'h00);
    do_read(3'd0, d); chk("R6 set wins over clear", d, 8'h08);

    // Summaries follow levels
    usub_flags = 8'h40;
    do_read(3'd0, d); chk("R3 U summary", d, 8'h04);
    usub_flags = 8'h00; ssub_flags = 8'h01;
    do_read(3'd0, d); chk("R3 U drops, S summary", d, 8'h02);
    gpio_flags = 8'h80;
    do_read(3'd0, d); chk("R3 S and GPIO", d, 8'h03);

    // Pins, reserved bits, unmapped addresses
    ext_pin0 = 1'b1; ext_pin1 = 1'b1;
    idle(3);
    do_read(3'd0, d); chk("R4 pin0 mirrored", d, 8'h13);
    do_read(3'd1, d); chk("R4 pin1 mirrored", d, 8'h01);
    do_read(3'd5, d); chk("R2 unmapped reads zero", d, 8'h00);
    do_write(3'd0, 8'hFF);
    do_read(3'd0, d); chk("R7 write to status ignored", d, 8'h13);
    ext_pin0 = 1'b0; ext_pin1 = 1'b0;
    idle(3);
    do_read(3'd1, d); chk("R4 pin1 released", d, 8'h00);

    // Enables and request
    do_write(3'd2, 8'hFF);
    do_read(3'd2, d); chk("R7 enable0 upper bits zero", d, 8'h1F);
    do_write(3'd3, 8'hFF);
    do_read(3'd3, d); chk("R7 enable1 bit0", d, 8'h01);
    do_write(3'd2, 8'h00); do_write(3'd3, 8'h00);
    idle(2);
    chk("R8 masked request low", {7'd0, cpu_irq}, 8'h00);
    do_write(3'd2, 8'h01);
    idle(2);
    chk("R8 enabled GPIO request high", {7'd0, cpu_irq}, 8'h01);

    // Constrained random phase, checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      usub_flags = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      ssub_flags = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      gpio_flags = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      if ($urandom % 12 == 0) ext_pin0 = ~ext_pin0;
      if ($urandom % 12 == 0) ext_pin1 = ~ext_pin1;
      clk_en    = 1'($urandom % 2);
      bus_rd    = ($urandom % 3 == 0);
      bus_wr    = ($urandom % 6 == 0);
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule